// File: doc/BRIEF.md
# Counting Level Interrupt Controller

This block gathers 32 level interrupt lines into two processor requests, a normal request and a fast request. A level bit is kept for each line. It is set when the line rises and cleared when the line falls. Two masks pick which latched lines drive each request: a software-controlled normal-request mask and a fast-request mask.

Software uses a small register window of 4 KiB. Two offsets can be read: one gives how many lines are both latched and enabled for the normal request, and the other gives the lowest such line number. Three offsets can be written: one arms a single line by index, one disarms a single line by index, and one wipes every latched level bit while keeping the masks. All state sits in registers, and every output is registered. Any access to an offset that does not support that direction reads zero, has no effect on state, and raises a one-cycle error flag.

Top module: `cnt_intc`

## Requirements
- R1: After a synchronous reset, the level bits, the normal mask and the count are zero, `irq_o`, `fiq_o` and `err_o` are low, and the fast mask holds the parameter `FIQ_INIT`. The fast mask has no write path.
- R2: A low-to-high change on `src_i[k]`, seen by comparing the input with the sample taken one clock earlier, sets level bit k in the same clock. The level bit is set whether or not line k is enabled.
- R3: A high-to-low change on `src_i[k]` clears level bit k in the same clock.
- R4: A read at offset 0x000 returns the number of lines whose level bit and normal-mask bit are both set. This holds when several lines change in one clock.
- R5: A read at offset 0x004 returns the lowest line number whose level bit and normal-mask bit are both set. It returns 0 when no such line exists.
- R6: A write at offset 0x010 sets the normal-mask bit whose index equals the whole of `wdata_i`. Any value of `N_SRC` or more has no effect.
- R7: A write at offset 0x00C clears the normal-mask bit whose index equals the whole of `wdata_i`. Any value of `N_SRC` or more has no effect.
- R8: A write at offset 0x008 clears every level bit and so the count, and leaves both masks unchanged. A line that stays high is not latched again until it makes a new rising edge.
- R9: `irq_o` is high exactly when some line has both its level bit and its normal-mask bit set. It follows every input change and register write in the same clock as the state.
- R10: `fiq_o` is high exactly when some line has both its level bit and its fast-mask bit set.
- R11: Each of the following sets `err_o` for exactly the next cycle: a read at any offset other than 0x000 or 0x004, or a write at any offset other than 0x008, 0x00C or 0x010. Such a read returns 0, and such a write changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | N_SRC | Interrupt lines, sampled every clock |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 12 | Byte offset in the 4 KiB window |
| wdata_i | input | DW | Write data (line index for arm and disarm) |
| rdata_o | output | DW | Read data, valid the clock after the read strobe |
| irq_o | output | 1 | Registered normal request |
| fiq_o | output | 1 | Registered fast request |
| err_o | output | 1 | One-cycle flag for an unsupported access |

## Verification
The bench raises three lines in a single clock. A design that adds at most one per clock would report a count that is too low. It arms index 33 while line 1 is latched but not armed. A decoder that keeps only the low index bits would arm line 1 and make the count grow. After a wipe it keeps lines high. A design that re-latches held levels, or that also clears the masks, shows a wrong count or a wrong lowest line number once a new edge arrives. It writes to an unused offset with a valid index and reads a write-only offset. A design that decodes loosely would change the count or return nonzero data, and a missing error flag shows up directly.

// File: rtl/cnt_intc_pkg.sv
package cnt_intc_pkg;
  localparam int unsigned OFS_W = 12;
  localparam logic [OFS_W-1:0] OFS_COUNT = 12'h000;
  localparam logic [OFS_W-1:0] OFS_FIRST = 12'h004;
  localparam logic [OFS_W-1:0] OFS_WIPE  = 12'h008;
  localparam logic [OFS_W-1:0] OFS_DROP  = 12'h00C;
  localparam logic [OFS_W-1:0] OFS_ARM   = 12'h010;
endpackage

// File: rtl/cnt_intc_edge.sv
module cnt_intc_edge #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_i,
  input  logic         wipe_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] lvl_next_o
);
  logic [N-1:0] smp_q, lvl_q, rise, fall;

  assign rise       = src_i & ~smp_q;
  assign fall       = ~src_i & smp_q;
  // wipe first, then the edges of this clock
  assign lvl_next_o = ((wipe_i ? '0 : lvl_q) | rise) & ~fall;
  assign lvl_o      = lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q <= '0;
      lvl_q <= '0;
    end else begin
      smp_q <= src_i;
      lvl_q <= lvl_next_o;
    end
  end
endmodule

// File: rtl/cnt_intc_mask.sv
module cnt_intc_mask #(
  parameter int unsigned N  = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm_i,
  input  logic          drop_i,
  input  logic [DW-1:0] idx_i,
  output logic [N-1:0]  en_o,
  output logic [N-1:0]  en_next_o
);
  logic [N-1:0] en_q;

  for (genvar j = 0; j < N; j++) begin : g_bit
    logic hit;
    assign hit = (idx_i == DW'(j));
    always_comb begin
      en_next_o[j] = en_q[j];
      if (arm_i && hit)       en_next_o[j] = 1'b1;
      else if (drop_i && hit) en_next_o[j] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_next_o;
  end

  assign en_o = en_q;
endmodule

// File: rtl/cnt_intc_prio.sv
module cnt_intc_prio #(
  parameter int unsigned N  = 32,
  parameter int unsigned IW = 5
) (
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (vec_i[k]) idx_o = IW'(k);
    end
  end
endmodule

// File: rtl/cnt_intc.sv
module cnt_intc
  import cnt_intc_pkg::*;
#(
  parameter int unsigned       N_SRC    = 32,
  parameter int unsigned       DW       = 32,
  parameter logic [N_SRC-1:0]  FIQ_INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [11:0]      addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             irq_o,
  output logic             fiq_o,
  output logic             err_o
);
  localparam int unsigned CNT_W = $clog2(N_SRC + 1);
  localparam int unsigned IW    = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic wipe, drop, arm, rd_cnt, rd_first, wr_bad, rd_bad;
  logic [N_SRC-1:0] lvl_q, lvl_d, irq_en_q, irq_en_d, fiq_en_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IW-1:0]    first_idx;

  assign wipe     = wr_en_i && (addr_i == OFS_WIPE);
  assign drop     = wr_en_i && (addr_i == OFS_DROP);
  assign arm      = wr_en_i && (addr_i == OFS_ARM);
  assign rd_cnt   = rd_en_i && (addr_i == OFS_COUNT);
  assign rd_first = rd_en_i && (addr_i == OFS_FIRST);
  assign wr_bad   = wr_en_i && !(wipe || drop || arm);
  assign rd_bad   = rd_en_i && !(rd_cnt || rd_first);

  cnt_intc_edge #(.N(N_SRC)) u_edge (
    .clk(clk), .rst(rst), .src_i(src_i), .wipe_i(wipe),
    .lvl_o(lvl_q), .lvl_next_o(lvl_d)
  );

  cnt_intc_mask #(.N(N_SRC), .DW(DW)) u_mask (
    .clk(clk), .rst(rst), .arm_i(arm), .drop_i(drop), .idx_i(wdata_i),
    .en_o(irq_en_q), .en_next_o(irq_en_d)
  );

  cnt_intc_prio #(.N(N_SRC), .IW(IW)) u_prio (
    .vec_i(lvl_q & irq_en_q), .idx_o(first_idx)
  );

  assign act_d = lvl_d & irq_en_d;

  always_comb begin
    cnt_d = '0;
    for (int k = 0; k < N_SRC; k++) cnt_d = cnt_d + CNT_W'(act_d[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fiq_en_q <= FIQ_INIT;
      cnt_q    <= '0;
      irq_o    <= 1'b0;
      fiq_o    <= 1'b0;
      err_o    <= 1'b0;
      rdata_o  <= '0;
    end else begin
      cnt_q <= cnt_d;
      irq_o <= |act_d;
      fiq_o <= |(lvl_d & fiq_en_q);
      err_o <= wr_bad || rd_bad;
      if (rd_en_i) begin
        if (rd_cnt)        rdata_o <= DW'(cnt_q);
        else if (rd_first) rdata_o <= DW'(first_idx);
        else               rdata_o <= '0;
      end
    end
  end
endmodule

// File: rtl/cnt_intc_chk.sv
module cnt_intc_chk #(
  parameter int unsigned      N        = 32,
  parameter int unsigned      CW       = 6,
  parameter logic [N-1:0]     FIQ_MASK = '0
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic         rd_en,
  input logic [11:0]  addr,
  input logic [N-1:0] lvl,
  input logic [N-1:0] en,
  input logic [CW-1:0] cnt,
  input logic         irq,
  input logic         fiq,
  input logic         err
);
  logic wr_ok, rd_ok;
  assign wr_ok = (addr == 12'h008) || (addr == 12'h00C) || (addr == 12'h010);
  assign rd_ok = (addr == 12'h000) || (addr == 12'h004);

  AST_CNT_MATCH: assert property (@(posedge clk) disable iff (rst)
    cnt == CW'($countones(lvl & en))); // R4
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq == |(lvl & en)); // R9
  AST_FIQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    fiq == |(lvl & FIQ_MASK)); // R10
  AST_WIPE_KEEPS_MASK: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 12'h008) |=> $stable(en)); // R8
  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (rst)
    ((wr_en && !wr_ok) || (rd_en && !rd_ok)) |=> err); // R11
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !rd_en) |=> !err); // R11
endmodule

bind cnt_intc cnt_intc_chk #(.N(N_SRC), .CW(CNT_W), .FIQ_MASK(FIQ_INIT)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en_i), .rd_en(rd_en_i), .addr(addr_i),
  .lvl(lvl_q), .en(irq_en_q), .cnt(cnt_q), .irq(irq_o), .fiq(fiq_o), .err(err_o)
);

// File: tb/cnt_intc_bench.sv
`timescale 1ns/1ps
module cnt_intc_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq, err;
  logic        rd_pipe = 1'b0;
  int          vecs = 0, miss = 0;
  bit          done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  cnt_intc #(.N_SRC(32), .DW(32), .FIQ_INIT(32'h0000_0020)) u_cnt_intc (
    .clk(clk), .rst(rst), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) rd_pipe <= rd_en;

  // monitor: pops one expected item per completed read
  always @(negedge clk) begin
    if (rd_pipe) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rdata === e, t, rdata, e);
    end
  end

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input bit exp_err, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(err === exp_err, {tag, " err"}, 32'(err), 32'(exp_err));
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit exp_err, input string tag);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    chk(err === exp_err, {tag, " err"}, 32'(err), 32'(exp_err));
  endtask

  task automatic set_src(input logic [31:0] v);
    @(negedge clk);
    src = v;
    @(negedge clk);
  endtask

  task automatic pins(input bit ei, input bit ef, input string tag);
    chk(irq === ei, {tag, " irq"}, 32'(irq), 32'(ei));
    chk(fiq === ef, {tag, " fiq"}, 32'(fiq), 32'(ef));
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miss++;
      vecs++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    pins(1'b0, 1'b0, "R1");
    chk(err === 1'b0, "R1 err", 32'(err), 0);
    rd(12'h000, 0, 1'b0, "R1 count");
    rd(12'h004, 0, 1'b0, "R1 first");
    // R2 line 3 rises while disarmed
    set_src(32'h0000_0008);
    pins(1'b0, 1'b0, "R2");
    rd(12'h000, 0, 1'b0, "R2 count");
    // R6 arm line 3: latched level now counts
    wr(12'h010, 3, 1'b0, "R6 arm");
    pins(1'b1, 1'b0, "R9");
    rd(12'h000, 1, 1'b0, "R6 count");
    rd(12'h004, 3, 1'b0, "R5 first");
    // R4 three rising edges in one clock
    wr(12'h010, 7, 1'b0, "R6 arm7");
    wr(12'h010, 10, 1'b0, "R6 arm10");
    set_src(32'h0000_048A);
    rd(12'h000, 3, 1'b0, "R4 count");
    rd(12'h004, 3, 1'b0, "R5 first");
    // R3 line 3 falls
    set_src(32'h0000_0482);
    rd(12'h000, 2, 1'b0, "R3 count");
    rd(12'h004, 7, 1'b0, "R5 first after fall");
    // R7 disarm line 7
    wr(12'h00C, 7, 1'b0, "R7 drop");
    rd(12'h000, 1, 1'b0, "R7 count");
    rd(12'h004, 10, 1'b0, "R7 first");
    // R6 index 33 out of range: line 1 is latched and must stay disarmed
    wr(12'h010, 33, 1'b0, "R6 wide");
    rd(12'h000, 1, 1'b0, "R6 wide index ignored");
    // R10 line 5 rises, fast mask holds line 5
    set_src(32'h0000_04A2);
    pins(1'b1, 1'b1, "R10");
    rd(12'h000, 1, 1'b0, "R10 count");
    // R8 wipe
    wr(12'h008, 0, 1'b0, "R8 wipe");
    pins(1'b0, 1'b0, "R8");
    rd(12'h000, 0, 1'b0, "R8 count");
    rd(12'h004, 0, 1'b0, "R8 first");
    set_src(32'h0000_04AA);
    rd(12'h000, 1, 1'b0, "R8 relatch only new edge");
    rd(12'h004, 3, 1'b0, "R8 mask kept");
    pins(1'b1, 1'b0, "R8 after edge");
    // R11 bad accesses
    rd(12'h100, 0, 1'b1, "R11 unmapped read");
    rd(12'h008, 0, 1'b1, "R11 read write-only");
    wr(12'h014, 1, 1'b1, "R11 unmapped write");
    rd(12'h000, 1, 1'b0, "R11 write ignored");
    wr(12'h000, 0, 1'b1, "R11 write read-only");
    @(negedge clk);
    chk(err === 1'b0, "R11 err one cycle", 32'(err), 0);
    // all lines low
    set_src(32'h0);
    pins(1'b0, 1'b0, "R3 all low");
    rd(12'h000, 0, 1'b0, "R3 count zero");
    rd(12'h004, 0, 1'b0, "R5 none");
    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
  end
endmodule